// File: doc/BRIEF.md
# Event State Buffer MMIO Controller

This block keeps a small table of event queue descriptors. Each descriptor carries two 2-bit coalescing states. One state (notification) gates forwarding of new events. The other (escalation) gates escalations. Each state is a pair of bits: P (pending, bit 1) and Q (queued, bit 0). Software reaches the states only through loads into a memory window. The load address picks the descriptor, which of its two states is addressed, and the operation to run on it. Each load may change state, and stores are refused.

A separate trigger input requests an event for one descriptor. If the descriptor is not flagged for unconditional notification, the notification state runs through the coalescing step. A notify pulse leaves the block only when the event has to be forwarded. If the descriptor is flagged, every trigger is forwarded and the state is left alone. Descriptor presence and the unconditional flag come in as per-descriptor vectors. The PQ states live inside the block, and a state register is updated only when its value really changes.

Top module: `esb_mmio_ctrl`

## Requirements
- R1: After reset every PQ state of every descriptor is 00, and rsp_valid and notify_valid are low.
- R2: The descriptor index is req_addr >> (PAGE_SHIFT+1). Bit PAGE_SHIFT selects the state: 0 for notification, 1 for escalation. Only req_addr[11:0] selects the operation, whatever PAGE_SHIFT is. PAGE_SHIFT must be 12 or 16.
- R3: Offsets 0x000-0x7FF perform end-of-interrupt. The transitions are 00->00, 10->00 and 01->01, each returning 0, and 11->10, which returns 1.
- R4: Offsets 0x800-0xBFF return {62'b0, P, Q} and leave the state unchanged.
- R5: Offsets 0xC00-0xFFF force the state to offset bits [9:8] and return the value held before the force.
- R6: A request is refused if it is a store, if req_bytes != 8, if req_bige = 0, or if req_addr[2:0] != 0. A refused request returns rsp_err = 1 with all-ones data and changes no state.
- R7: A load to a descriptor whose index is NUM_DESC or more, or whose desc_valid bit is 0, returns all-ones data with rsp_err = 0 and changes no state.
- R8: A trigger on a valid descriptor with desc_ucond = 0 moves the notification state as follows: 00->10 with notify, 10->11, 11->11 and 01->01 without notify. The escalation state is untouched.
- R9: A trigger on a valid descriptor with desc_ucond = 1 always notifies and changes no state. A trigger on an absent or invalid descriptor neither notifies nor changes state.
- R10: A trigger and a load that address the same notification state in the same cycle are serialised with the trigger first. The load observes and acts on the post-trigger value.
- R11: rsp_valid rises exactly one cycle after each accepted request. notify_valid and notify_idx appear exactly one cycle after the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | NUM_DESC | Per-descriptor valid bit |
| desc_ucond | input | NUM_DESC | Per-descriptor unconditional-notify flag |
| req_valid | input | 1 | Window access request |
| req_write | input | 1 | 1 for store, 0 for load |
| req_addr | input | ADDR_W | Byte address within the window |
| req_bytes | input | 4 | Access size in bytes |
| req_bige | input | 1 | 1 when the access is big-endian |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 64 | Load result |
| rsp_err | output | 1 | Access refused |
| trig_valid | input | 1 | Event trigger request |
| trig_idx | input | IDX_W | Descriptor addressed by the trigger |
| notify_valid | output | 1 | Event forwarded |
| notify_idx | output | IDX_W | Descriptor of the forwarded event |

## Verification
Every descriptor, both states, all four start values and all three operation classes are swept against an arithmetic model. A wrong EOI table or a reversed P/Q bit order would therefore show up as a wrong return or read-back value. A second instance with 64 KB pages places the operation bits among ignored page-offset bits. A design that decodes the operation from the page top would pick the wrong operation. Refused stores, bad sizes, invalid descriptors and absent indices are each followed by a read-back, which exposes any state that leaked. A same-cycle trigger and load on one state checks the serialisation: a design that lets the load see the old value returns 00 where 10 is expected.

// File: rtl/esb_pkg.sv
package esb_pkg;

   typedef logic [1:0] pq_t;

   localparam pq_t PQ_RESET = 2'b00;

   typedef enum logic [1:0] {
      OP_EOI = 2'd0,
      OP_GET = 2'd1,
      OP_SET = 2'd2
   } esb_op_e;

   // next state of the coalescing step on a new event
   function automatic pq_t pq_on_event(pq_t cur);
      pq_t nxt;
      case (cur)
         2'b00:   nxt = 2'b10;
         2'b10:   nxt = 2'b11;
         2'b11:   nxt = 2'b11;
         default: nxt = cur;
      endcase
      return nxt;
   endfunction

   function automatic logic pq_forwards(pq_t cur);
      return cur == 2'b00;
   endfunction

   // next state after end-of-interrupt
   function automatic pq_t pq_on_eoi(pq_t cur);
      pq_t nxt;
      case (cur)
         2'b10:   nxt = 2'b00;
         2'b11:   nxt = 2'b10;
         default: nxt = cur;
      endcase
      return nxt;
   endfunction

   function automatic logic pq_eoi_replay(pq_t cur);
      return cur == 2'b11;
   endfunction

endpackage

// File: rtl/esb_addr_decode.sv
module esb_addr_decode
   import esb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_SHIFT = 12,
   parameter int NUM_DESC   = 4,
   localparam int IDX_W     = ADDR_W - PAGE_SHIFT - 1
) (
   input  logic [IDX_W-1:0] idx_bits,
   input  logic             side_bit,
   input  logic [3:0]       op_bits,
   input  logic [2:0]       align_bits,
   output logic [IDX_W-1:0] idx,
   output logic             side_esc,
   output esb_op_e          op,
   output pq_t              force_val,
   output logic             idx_present,
   output logic             aligned
);
   assign idx       = idx_bits;
   assign side_esc  = side_bit;
   assign force_val = op_bits[1:0];
   assign aligned   = (align_bits == 3'b000);

   always_comb begin
      if (!op_bits[3])      op = OP_EOI;
      else if (!op_bits[2]) op = OP_GET;
      else                  op = OP_SET;
   end

   generate
      if ((1 << IDX_W) > NUM_DESC) begin : g_partial
         assign idx_present = (idx_bits < IDX_W'(NUM_DESC));
      end else begin : g_full
         assign idx_present = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/esb_pq_cell.sv
module esb_pq_cell
   import esb_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    ld_hit,
   input  logic    ld_esc,
   input  esb_op_e ld_op,
   input  pq_t     ld_force,
   input  logic    tr_hit,
   output logic [1:0] ld_ret,
   output logic    tr_fwd
);
   pq_t pq_n, pq_e;
   pq_t n_post_trig, target, target_new;
   pq_t nxt_n, nxt_e;

   always_comb begin
      n_post_trig = tr_hit ? pq_on_event(pq_n) : pq_n;
      tr_fwd      = tr_hit & pq_forwards(pq_n);
      target      = ld_esc ? pq_e : n_post_trig;
      target_new  = target;
      ld_ret      = 2'b00;
      case (ld_op)
         OP_EOI: begin
            target_new = pq_on_eoi(target);
            ld_ret     = {1'b0, pq_eoi_replay(target)};
         end
         OP_GET: ld_ret = target;
         default: begin
            target_new = ld_force;
            ld_ret     = target;
         end
      endcase
      nxt_n = (ld_hit && !ld_esc) ? target_new : n_post_trig;
      nxt_e = (ld_hit &&  ld_esc) ? target_new : pq_e;
   end

   // registers update only on a real change of value
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pq_n <= PQ_RESET;
         pq_e <= PQ_RESET;
      end else begin
         if (nxt_n != pq_n) pq_n <= nxt_n;
         if (nxt_e != pq_e) pq_e <= nxt_e;
      end
   end

endmodule

// File: rtl/esb_mmio_ctrl.sv
module esb_mmio_ctrl
   import esb_pkg::*;
#(
   parameter int NUM_DESC   = 4,
   parameter int PAGE_SHIFT = 12,
   parameter int ADDR_W     = 16,
   localparam int IDX_W     = ADDR_W - PAGE_SHIFT - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_DESC-1:0] desc_valid,
   input  logic [NUM_DESC-1:0] desc_ucond,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [3:0]          req_bytes,
   input  logic                req_bige,
   output logic                rsp_valid,
   output logic [63:0]         rsp_data,
   output logic                rsp_err,
   input  logic                trig_valid,
   input  logic [IDX_W-1:0]    trig_idx,
   output logic                notify_valid,
   output logic [IDX_W-1:0]    notify_idx
);
   localparam int ACCESS_BYTES = 8;

   generate
      if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
         $error("PAGE_SHIFT must be 12 or 16");
      end
      if (NUM_DESC < 1) begin : g_bad_count
         $error("NUM_DESC must be at least 1");
      end
      if ((1 << IDX_W) < NUM_DESC) begin : g_bad_width
         $error("ADDR_W too narrow for NUM_DESC");
      end
   endgenerate

   logic [IDX_W-1:0] ld_idx;
   logic             ld_esc, idx_present, aligned;
   esb_op_e          ld_op;
   pq_t              ld_force;

   esb_addr_decode #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .NUM_DESC(NUM_DESC)
   ) u_dec (
      .idx_bits   (req_addr[ADDR_W-1:PAGE_SHIFT+1]),
      .side_bit   (req_addr[PAGE_SHIFT]),
      .op_bits    (req_addr[11:8]),
      .align_bits (req_addr[2:0]),
      .idx        (ld_idx),
      .side_esc   (ld_esc),
      .op         (ld_op),
      .force_val  (ld_force),
      .idx_present(idx_present),
      .aligned    (aligned)
   );

   logic acc_ok, acc_err, ld_live;
   assign acc_ok  = req_valid && !req_write && (req_bytes == 4'(ACCESS_BYTES))
                    && req_bige && aligned;
   assign acc_err = req_valid && !acc_ok;

   logic ld_desc_ok;
   logic tr_present, tr_desc_ok, tr_ucond;
   always_comb begin
      ld_desc_ok = 1'b0;
      tr_desc_ok = 1'b0;
      tr_ucond   = 1'b0;
      for (int d = 0; d < NUM_DESC; d++) begin
         if (ld_idx == IDX_W'(d)) ld_desc_ok = desc_valid[d];
         if (trig_idx == IDX_W'(d)) begin
            tr_desc_ok = desc_valid[d];
            tr_ucond   = desc_ucond[d];
         end
      end
   end
   assign ld_live    = acc_ok && idx_present && ld_desc_ok;
   assign tr_present = trig_valid && tr_desc_ok;

   logic [NUM_DESC-1:0] cell_ld_hit, cell_tr_hit, cell_fwd;
   logic [1:0]          cell_ret [NUM_DESC];

   generate
      for (genvar d = 0; d < NUM_DESC; d++) begin : g_cell
         assign cell_ld_hit[d] = ld_live && (ld_idx == IDX_W'(d));
         assign cell_tr_hit[d] = tr_present && !tr_ucond && (trig_idx == IDX_W'(d));
         esb_pq_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_hit  (cell_ld_hit[d]),
            .ld_esc  (ld_esc),
            .ld_op   (ld_op),
            .ld_force(ld_force),
            .tr_hit  (cell_tr_hit[d]),
            .ld_ret  (cell_ret[d]),
            .tr_fwd  (cell_fwd[d])
         );
      end
   endgenerate

   logic [1:0] sel_ret;
   always_comb begin
      sel_ret = 2'b00;
      for (int d = 0; d < NUM_DESC; d++)
         if (cell_ld_hit[d]) sel_ret = cell_ret[d];
   end

   logic fwd_now;
   assign fwd_now = tr_present && (tr_ucond || (|cell_fwd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_err      <= 1'b0;
         rsp_data     <= '0;
         notify_valid <= 1'b0;
         notify_idx   <= '0;
      end else begin
         rsp_valid    <= req_valid;
         rsp_err      <= acc_err;
         rsp_data     <= ld_live ? {62'b0, sel_ret} : '1;
         notify_valid <= fwd_now;
         notify_idx   <= fwd_now ? trig_idx : '0;
      end
   end

endmodule

// File: rtl/esb_mmio_chk.sv
module esb_mmio_chk #(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [63:0]       rsp_data,
   input logic              rsp_err,
   input logic              trig_valid,
   input logic [IDX_W-1:0]  trig_idx,
   input logic              notify_valid,
   input logic [IDX_W-1:0]  notify_idx
);
   a_r11_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r11_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r6_store_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_err && rsp_data == '1));
   a_r6_misaligned_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr[2:0] != 3'b000) |=> rsp_err);
   a_r6_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == '1));
   a_r4_narrow_result: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_data != '1) |-> (rsp_data[63:2] == '0));
   a_r11_notify_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
      notify_valid |-> ($past(trig_valid) && notify_idx == $past(trig_idx)));
   a_r9_no_trig_no_notify: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_valid |=> !notify_valid);
endmodule

bind esb_mmio_ctrl esb_mmio_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
   .rsp_err(rsp_err), .trig_valid(trig_valid), .trig_idx(trig_idx),
   .notify_valid(notify_valid), .notify_idx(notify_idx)
);

// File: tb/esb_mmio_ctrl_test.sv
module esb_mmio_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int AW = 16;
   localparam int IW = 3;
   localparam int AWB = 20;

   logic clk = 0;
   logic rst_n = 0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [N-1:0] desc_valid = '1, desc_ucond = '0;
   logic req_valid = 0, req_write = 0, req_bige = 1;
   logic [AW-1:0] req_addr = '0;
   logic [3:0] req_bytes = 4'd8;
   logic rsp_valid, rsp_err;
   logic [63:0] rsp_data;
   logic trig_valid = 0;
   logic [IW-1:0] trig_idx = '0;
   logic notify_valid;
   logic [IW-1:0] notify_idx;

   esb_mmio_ctrl #(.NUM_DESC(N), .PAGE_SHIFT(12), .ADDR_W(AW)) uut (
      .clk, .rst_n, .desc_valid, .desc_ucond, .req_valid, .req_write,
      .req_addr, .req_bytes, .req_bige, .rsp_valid, .rsp_data, .rsp_err,
      .trig_valid, .trig_idx, .notify_valid, .notify_idx);

   // 64 KB page instance
   logic b_req_valid = 0;
   logic [AWB-1:0] b_req_addr = '0;
   logic b_rsp_valid, b_rsp_err, b_notify_valid;
   logic [63:0] b_rsp_data;
   logic [IW-1:0] b_notify_idx;

   esb_mmio_ctrl #(.NUM_DESC(N), .PAGE_SHIFT(16), .ADDR_W(AWB)) uut_big (
      .clk, .rst_n, .desc_valid({N{1'b1}}), .desc_ucond({N{1'b0}}),
      .req_valid(b_req_valid), .req_write(1'b0), .req_addr(b_req_addr),
      .req_bytes(4'd8), .req_bige(1'b1), .rsp_valid(b_rsp_valid),
      .rsp_data(b_rsp_data), .rsp_err(b_rsp_err), .trig_valid(1'b0),
      .trig_idx('0), .notify_valid(b_notify_valid), .notify_idx(b_notify_idx));

   int checks = 0, fails = 0;
   logic [1:0] model [N][2];

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] m_event(logic [1:0] s);
      if (s == 2'd0) return 2'd2;
      if (s == 2'd1) return 2'd1;
      return 2'd3;
   endfunction
   function automatic logic [1:0] m_eoi(logic [1:0] s);
      if (s[1] == 1'b0) return s;
      return {s[0], 1'b0};
   endfunction

   function automatic logic [AW-1:0] a_of(int d, int side, int off);
      return AW'((d << 13) + (side << 12) + off);
   endfunction

   logic [63:0] r_data;
   logic r_err, r_valid;

   task automatic access(logic [AW-1:0] a, logic wr, logic [3:0] sz, logic be);
      @(negedge clk);
      req_valid = 1; req_addr = a; req_write = wr; req_bytes = sz; req_bige = be;
      @(posedge clk);
      @(negedge clk);
      r_data = rsp_data; r_err = rsp_err; r_valid = rsp_valid;
      req_valid = 0; req_write = 0; req_bytes = 4'd8; req_bige = 1;
   endtask

   task automatic load(logic [AW-1:0] a);
      access(a, 1'b0, 4'd8, 1'b1);
      chk("R11", {63'b0, r_valid}, 64'd1);
   endtask

   task automatic trigger(int d, output logic nv, output logic [IW-1:0] ni);
      @(negedge clk);
      trig_valid = 1; trig_idx = IW'(d);
      @(posedge clk);
      @(negedge clk);
      nv = notify_valid; ni = notify_idx;
      trig_valid = 0;
   endtask

   task automatic big_load(logic [AWB-1:0] a);
      @(negedge clk);
      b_req_valid = 1; b_req_addr = a;
      @(posedge clk);
      @(negedge clk);
      r_data = b_rsp_data;
      b_req_valid = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic nv;
      logic [IW-1:0] ni;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 rsp_valid", {63'b0, rsp_valid}, 0);
      chk("R1 notify", {63'b0, notify_valid}, 0);
      rst_n = 1;
      for (int d = 0; d < N; d++)
         for (int s = 0; s < 2; s++) begin
            model[d][s] = 2'd0;
            load(a_of(d, s, 'h800));
            chk("R1 reset pq", r_data, 0);
         end

      // R5/R4/R2: force sweep with read-back
      for (int d = 0; d < N; d++)
         for (int s = 0; s < 2; s++)
            for (int v = 0; v < 4; v++) begin
               load(a_of(d, s, 'hC00 + v * 'h100 + 8 * (v + 1)));
               chk("R5 set returns old", r_data, {62'b0, model[d][s]});
               model[d][s] = 2'(v);
               load(a_of(d, s, 'h800 + 'h3F8 * (v % 2)));
               chk("R4 get", r_data, {62'b0, model[d][s]});
               chk("R2 err", {63'b0, r_err}, 0);
            end
      // other state of each descriptor untouched: both ended at 11
      for (int d = 0; d < N; d++) begin
         load(a_of(d, 0, 'h808));
         chk("R2 even page", r_data, {62'b0, model[d][0]});
      end

      // R3: EOI sweep
      for (int d = 0; d < N; d++)
         for (int s = 0; s < 2; s++)
            for (int v = 0; v < 4; v++) begin
               load(a_of(d, s, 'hC00 + v * 'h100));
               model[d][s] = 2'(v);
               load(a_of(d, s, 8 * d + 'h100 * v));
               chk("R3 eoi return", r_data, (v == 3) ? 64'd1 : 64'd0);
               model[d][s] = m_eoi(model[d][s]);
               load(a_of(d, s, 'h800));
               chk("R3 eoi state", r_data, {62'b0, model[d][s]});
            end

      // R8: trigger sweep on notification state
      for (int d = 0; d < N; d++) begin
         load(a_of(d, 1, 'hE00)); model[d][1] = 2'd2;
         for (int v = 0; v < 4; v++) begin
            load(a_of(d, 0, 'hC00 + v * 'h100)); model[d][0] = 2'(v);
            trigger(d, nv, ni);
            chk("R8 notify", {63'b0, nv}, (v == 0) ? 64'd1 : 64'd0);
            if (v == 0) chk("R8 notify idx", {61'b0, ni}, 64'(d));
            model[d][0] = m_event(model[d][0]);
            load(a_of(d, 0, 'h800));
            chk("R8 state", r_data, {62'b0, model[d][0]});
            load(a_of(d, 1, 'h800));
            chk("R8 esc untouched", r_data, {62'b0, model[d][1]});
         end
      end

      // R9: unconditional descriptor
      desc_ucond[1] = 1;
      load(a_of(1, 0, 'hD00)); model[1][0] = 2'd1;
      trigger(1, nv, ni);
      chk("R9 ucond notify", {63'b0, nv}, 1);
      load(a_of(1, 0, 'h800));
      chk("R9 ucond state", r_data, 1);
      desc_ucond[1] = 0;

      // R7/R9: invalid and absent descriptors
      load(a_of(2, 0, 'hC00)); model[2][0] = 2'd0;
      desc_valid[2] = 0;
      load(a_of(2, 0, 'hF00));
      chk("R7 invalid data", r_data, '1);
      chk("R7 invalid err", {63'b0, r_err}, 0);
      trigger(2, nv, ni);
      chk("R9 invalid trigger", {63'b0, nv}, 0);
      desc_valid[2] = 1;
      load(a_of(2, 0, 'h800));
      chk("R7 invalid unchanged", r_data, 0);
      load(a_of(5, 0, 'h800));
      chk("R7 absent data", r_data, '1);
      trigger(6, nv, ni);
      chk("R9 absent trigger", {63'b0, nv}, 0);

      // R6: refused accesses
      access(a_of(2, 0, 'hF00), 1'b1, 4'd8, 1'b1);
      chk("R6 store err", {63'b0, r_err}, 1);
      chk("R6 store data", r_data, '1);
      access(a_of(2, 0, 'hF00), 1'b0, 4'd4, 1'b1);
      chk("R6 size err", {63'b0, r_err}, 1);
      access(a_of(2, 0, 'hF00), 1'b0, 4'd8, 1'b0);
      chk("R6 endian err", {63'b0, r_err}, 1);
      access(a_of(2, 0, 'hF04), 1'b0, 4'd8, 1'b1);
      chk("R6 align err", {63'b0, r_err}, 1);
      load(a_of(2, 0, 'h800));
      chk("R6 state unchanged", r_data, 0);

      // R10: same-cycle trigger and load on the notification state
      load(a_of(3, 0, 'hC00));
      @(negedge clk);
      trig_valid = 1; trig_idx = 3'd3;
      req_valid = 1; req_addr = a_of(3, 0, 'h800);
      @(posedge clk);
      @(negedge clk);
      chk("R10 load sees trigger", rsp_data, 2);
      chk("R10 notify", {63'b0, notify_valid}, 1);
      trig_valid = 0; req_valid = 0;
      @(negedge clk);
      trig_valid = 1; trig_idx = 3'd3;
      req_valid = 1; req_addr = a_of(3, 0, 'h000);
      @(posedge clk);
      @(negedge clk);
      chk("R10 eoi after trigger", rsp_data, 1);
      trig_valid = 0; req_valid = 0;
      load(a_of(3, 0, 'h800));
      chk("R10 final state", r_data, 2);

      // R2: 64 KB pages, operation from low 12 bits only
      big_load(AWB'((1 << 17) + (1 << 16) + 'h5F00));
      chk("R2 big set old", r_data, 0);
      big_load(AWB'((1 << 17) + (1 << 16) + 'hA800));
      chk("R2 big get", r_data, 3);
      big_load(AWB'((1 << 17) + 'h7800));
      chk("R2 big even page", r_data, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule